// File: doc/BRIEF.md
# Network Transaction Admission Handler

This block sits between a node's network interface and its local transaction queue. Transaction descriptors arrive from the network as four 32-bit words on a valid/ready stream. The first word is a header that carries the transaction ID, the opcode and the two network addresses. The block reads that header and decides where the whole descriptor goes. An admitted descriptor passes unchanged to the local queue stream. A refused one leaves on a separate reject stream, with a rewritten header, so that the network side can send it back to the node that issued it.

The block allows only a limited number of received transactions to be outstanding at the same time. Every admitted descriptor whose opcode asks the node to start work takes one slot. Software frees a slot with a one-cycle completion pulse. When all slots are taken, further work-starting descriptors are refused. Descriptors that only carry data or report a refusal are always admitted and take no slot. The current slot count is brought out as an output.

Top module: `txn_admit`

## Requirements
- R1: A descriptor is four consecutive 32-bit words. The first is the header: [31:28] transaction ID, [27:24] opcode, [23:12] source network address, [11:0] target network address. It is followed by a source address word, a target address word and a length word. An admitted descriptor appears on the queue stream word for word, in order and unchanged.
- R2: A descriptor takes one slot when it is admitted and its opcode is anything other than 2 (data send) or 3 (reject). This covers 1 request, 4 direct delivery, 5 multicast delivery, 6 stream and any unassigned value. `live_count` rises by one on the clock edge that accepts such a header.
- R3: While `live_count` equals MAX_OUTSTANDING (default 8), a slot-taking descriptor is refused. All four of its words leave on the reject stream, and `live_count` never exceeds MAX_OUTSTANDING.
- R4: A refused descriptor's header is rewritten with opcode 3. Its source and target network address fields are exchanged and its transaction ID is kept. The remaining three words are passed on unchanged.
- R5: Descriptors with opcode 2 or 3 always go to the queue stream and leave `live_count` unchanged, even when all slots are taken.
- R6: A `done_pulse` lowers `live_count` by one on the next edge. When `live_count` is zero the pulse is ignored and the count stays at zero.
- R7: If a completion pulse and a slot-taking admission fall on the same edge, `live_count` is unchanged. The admission decision uses the count held before that edge, so a header arriving at full count is still refused even when a completion pulse falls in the same cycle.
- R8: Only the stream chosen for the current descriptor shows valid. `net_ready` equals the ready input of that stream, and a word moves only when both valid and ready are high.
- R9: After reset, `live_count` is zero, no output valid is high while `net_valid` is low, and the next accepted word is treated as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| net_valid | input | 1 | Descriptor word from the network is valid |
| net_ready | output | 1 | Block can take the network word |
| net_data | input | 32 | Descriptor word from the network |
| q_valid | output | 1 | Admitted word valid toward the local queue |
| q_ready | input | 1 | Local queue accepts the word |
| q_data | output | 32 | Admitted descriptor word |
| rej_valid | output | 1 | Refused word valid toward the return path |
| rej_ready | input | 1 | Return path accepts the word |
| rej_data | output | 32 | Refused descriptor word, header rewritten |
| done_pulse | input | 1 | Software signals that one received transaction has completed |
| live_count | output | 4 | Number of occupied admission slots |

## Verification
Two situations are the hardest to reach from the ports. The first is a completion pulse that lands on the same edge as a refused header at full count. The bench reaches it by filling all eight slots with request descriptors and then holding `done_pulse` high exactly in the cycle its own word counter marks as a header transfer. The second is a descriptor being refused while the return stream stalls. The bench reaches it by driving both ready inputs at random while the slots are full. A behavioural reference model follows every transfer, and a long random phase mixes all opcodes with random completions and backpressure.

// File: rtl/txn_admit_pkg.sv
package txn_admit_pkg;

    localparam int WORD_W  = 32;
    localparam int ID_W    = 4;
    localparam int OP_W    = 4;
    localparam int NADDR_W = 12;

    localparam logic [OP_W-1:0] OP_REQUEST = 4'd1;
    localparam logic [OP_W-1:0] OP_SEND    = 4'd2;
    localparam logic [OP_W-1:0] OP_REFUSE  = 4'd3;
    localparam logic [OP_W-1:0] OP_DELIVER = 4'd4;
    localparam logic [OP_W-1:0] OP_MCAST   = 4'd5;
    localparam logic [OP_W-1:0] OP_STREAM  = 4'd6;

    typedef struct packed {
        logic [ID_W-1:0]    txn_id;
        logic [OP_W-1:0]    opcode;
        logic [NADDR_W-1:0] from_node;
        logic [NADDR_W-1:0] to_node;
    } hdr_t;

    typedef enum logic {ROUTE_QUEUE = 1'b0, ROUTE_RETURN = 1'b1} route_e;

    // Data-only and refusal traffic never occupies a slot.
    function automatic logic takes_slot(input logic [OP_W-1:0] op);
        return (op != OP_SEND) && (op != OP_REFUSE);
    endfunction

    function automatic hdr_t refuse_hdr(input hdr_t h);
        hdr_t r;
        r.txn_id    = h.txn_id;
        r.opcode    = OP_REFUSE;
        r.from_node = h.to_node;
        r.to_node   = h.from_node;
        return r;
    endfunction

endpackage

// File: rtl/txn_admit_framer.sv
module txn_admit_framer
    import txn_admit_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   fire,
    input  route_e hdr_route,
    output logic   at_hdr,
    output route_e route_now
);
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    logic [IDX_W-1:0] idx_q;
    route_e           route_q;

    assign at_hdr    = (idx_q == '0);
    assign route_now = at_hdr ? hdr_route : route_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            route_q <= ROUTE_QUEUE;
        end else if (fire) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
            if (at_hdr) begin
                route_q <= hdr_route;
            end
        end
    end
endmodule

// File: rtl/txn_admit_slots.sv
module txn_admit_slots #(
    parameter int MAX_OUTSTANDING = 8,
    localparam int CNT_W = $clog2(MAX_OUTSTANDING + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             release_req,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    logic release_ok;

    assign release_ok = release_req && (count != '0);
    assign full       = (count >= CNT_W'(MAX_OUTSTANDING));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case ({take, release_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/txn_admit.sv
module txn_admit
    import txn_admit_pkg::*;
#(
    parameter int MAX_OUTSTANDING = 8,
    parameter int DESC_WORDS      = 4,
    localparam int CNT_W = $clog2(MAX_OUTSTANDING + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              net_valid,
    output logic              net_ready,
    input  logic [WORD_W-1:0] net_data,
    output logic              q_valid,
    input  logic              q_ready,
    output logic [WORD_W-1:0] q_data,
    output logic              rej_valid,
    input  logic              rej_ready,
    output logic [WORD_W-1:0] rej_data,
    input  logic              done_pulse,
    output logic [CNT_W-1:0]  live_count
);
    hdr_t   hdr_in;
    logic   wants_slot;
    logic   slots_full;
    logic   at_hdr;
    logic   fire;
    logic   take;
    route_e hdr_route;
    route_e route_now;

    assign hdr_in     = hdr_t'(net_data);
    assign wants_slot = takes_slot(hdr_in.opcode);
    assign hdr_route  = (wants_slot && slots_full) ? ROUTE_RETURN : ROUTE_QUEUE;

    txn_admit_framer #(.WORDS(DESC_WORDS)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .hdr_route (hdr_route),
        .at_hdr    (at_hdr),
        .route_now (route_now)
    );

    assign net_ready = (route_now == ROUTE_RETURN) ? rej_ready : q_ready;
    assign fire      = net_valid && net_ready;
    assign q_valid   = net_valid && (route_now == ROUTE_QUEUE);
    assign rej_valid = net_valid && (route_now == ROUTE_RETURN);
    assign q_data    = net_data;
    assign rej_data  = at_hdr ? WORD_W'(refuse_hdr(hdr_in)) : net_data;
    assign take      = fire && at_hdr && wants_slot && (hdr_route == ROUTE_QUEUE);

    txn_admit_slots #(.MAX_OUTSTANDING(MAX_OUTSTANDING)) u_slots (
        .clk         (clk),
        .rst         (rst),
        .take        (take),
        .release_req (done_pulse),
        .count       (live_count),
        .full        (slots_full)
    );
endmodule

// File: rtl/txn_admit_chk.sv
module txn_admit_chk #(
    parameter int MAX_OUTSTANDING = 8,
    parameter int DESC_WORDS      = 4,
    localparam int CNT_W = $clog2(MAX_OUTSTANDING + 1),
    localparam int IDX_W = (DESC_WORDS > 1) ? $clog2(DESC_WORDS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             net_valid,
    input logic             net_ready,
    input logic [31:0]      net_data,
    input logic             q_valid,
    input logic             q_ready,
    input logic             rej_valid,
    input logic             rej_ready,
    input logic [31:0]      rej_data,
    input logic             done_pulse,
    input logic [CNT_W-1:0] live_count
);
    logic [IDX_W-1:0] seen_idx;
    logic             hdr_fire;

    assign hdr_fire = net_valid && net_ready && (seen_idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_idx <= '0;
        end else if (net_valid && net_ready) begin
            seen_idx <= (seen_idx == IDX_W'(DESC_WORDS - 1)) ? '0 : seen_idx + 1'b1;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        live_count <= CNT_W'(MAX_OUTSTANDING)); // R3

    AST_REFUSE_AT_FULL: assert property (@(posedge clk) disable iff (rst)
        (rej_valid && seen_idx == '0) |-> (live_count == CNT_W'(MAX_OUTSTANDING))); // R3

    AST_REFUSE_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (rej_valid && seen_idx == '0) |-> (rej_data[27:24] == 4'd3 && rej_data[31:28] == net_data[31:28])); // R4

    AST_REFUSE_SWAP: assert property (@(posedge clk) disable iff (rst)
        (rej_valid && seen_idx == '0) |-> (rej_data[23:12] == net_data[11:0] && rej_data[11:0] == net_data[23:12])); // R4

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (live_count == '0 && done_pulse && !hdr_fire) |=> (live_count == '0)); // R6

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!done_pulse && !hdr_fire) |=> $stable(live_count)); // R2

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({q_valid, rej_valid})); // R8

    AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> (net_ready == q_ready)); // R8
endmodule

bind txn_admit txn_admit_chk #(
    .MAX_OUTSTANDING (MAX_OUTSTANDING),
    .DESC_WORDS      (DESC_WORDS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .net_valid  (net_valid),
    .net_ready  (net_ready),
    .net_data   (net_data),
    .q_valid    (q_valid),
    .q_ready    (q_ready),
    .rej_valid  (rej_valid),
    .rej_ready  (rej_ready),
    .rej_data   (rej_data),
    .done_pulse (done_pulse),
    .live_count (live_count)
);

// File: tb/tb_txn_admit.sv
module tb_txn_admit;
    localparam int MAXO = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        net_valid = 1'b0;
    logic        net_ready;
    logic [31:0] net_data = '0;
    logic        q_valid;
    logic        q_ready = 1'b0;
    logic [31:0] q_data;
    logic        rej_valid;
    logic        rej_ready = 1'b0;
    logic [31:0] rej_data;
    logic        done_pulse = 1'b0;
    logic [3:0]  live_count;

    always #2 clk = ~clk;

    txn_admit dut (
        .clk(clk), .rst(rst),
        .net_valid(net_valid), .net_ready(net_ready), .net_data(net_data),
        .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data),
        .rej_valid(rej_valid), .rej_ready(rej_ready), .rej_data(rej_data),
        .done_pulse(done_pulse), .live_count(live_count)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model state
    logic [31:0] pend[$];
    bit  cur_v  = 0;
    int  widx   = 0;
    bit  mroute = 0;
    int  mcnt   = 0;
    int  rej_seen = 0;
    int  q_hdr_seen = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_desc(input int id, input int op, input int src, input int tgt);
        pend.push_back({id[3:0], op[3:0], src[11:0], tgt[11:0]});
        pend.push_back(32'hA000_0000 | (id << 8) | src);
        pend.push_back(32'hB000_0000 | (id << 8) | tgt);
        pend.push_back(32'h0000_0040 + id);
    endtask

    task automatic cycle(input bit force_rdy, input int pv, input int pdone, input bit done_on_hdr);
        bit hdr, cons, rej, exp_rdy, fire, dec;
        logic [31:0] w, exp_rd;
        @(negedge clk);
        chk(live_count == 4'(mcnt), "R2 R6 R7 slot count", 32'(live_count), 32'(mcnt));
        if (!cur_v && pend.size() > 0 && ($urandom % 100) < pv) cur_v = 1;
        net_valid = cur_v;
        w = cur_v ? pend[0] : 32'h0;
        net_data = w;
        q_ready   = force_rdy ? 1'b1 : (($urandom % 100) < 60);
        rej_ready = force_rdy ? 1'b1 : (($urandom % 100) < 60);
        done_pulse = done_on_hdr ? (cur_v && widx == 0) : (($urandom % 100) < pdone);
        #1;
        hdr  = (widx == 0);
        cons = (w[27:24] != 4'd2) && (w[27:24] != 4'd3);
        rej  = hdr ? (cons && mcnt >= MAXO) : mroute;
        exp_rdy = rej ? rej_ready : q_ready;
        chk(q_valid == (cur_v && !rej), "R3 R5 R8 q_valid", 32'(q_valid), 32'(cur_v && !rej));
        chk(rej_valid == (cur_v && rej), "R3 R8 rej_valid", 32'(rej_valid), 32'(cur_v && rej));
        chk(net_ready == exp_rdy, "R8 net_ready", 32'(net_ready), 32'(exp_rdy));
        if (cur_v && !rej) chk(q_data == w, "R1 queue word", q_data, w);
        if (cur_v && rej) begin
            exp_rd = hdr ? {w[31:28], 4'h3, w[11:0], w[23:12]} : w;
            chk(rej_data == exp_rd, "R4 returned word", rej_data, exp_rd);
        end
        fire = cur_v && exp_rdy;
        dec  = done_pulse && (mcnt > 0);
        if (fire) begin
            void'(pend.pop_front());
            cur_v = 0;
            if (hdr) begin
                mroute = rej;
                if (rej) rej_seen++; else q_hdr_seen++;
                if (cons && !rej) mcnt++;
            end
            widx = (widx + 1) % 4;
        end
        if (dec) mcnt--;
    endtask

    task automatic drain(input bit force_rdy, input bit done_on_hdr);
        int guard = 0;
        while ((pend.size() > 0 || cur_v) && guard < 2000) begin
            cycle(force_rdy, 100, 0, done_on_hdr);
            guard++;
        end
        repeat (3) cycle(1, 100, 0, 0);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(live_count == 0, "R9 reset count", 32'(live_count), 0);
        chk(!q_valid && !rej_valid, "R9 reset valids", {q_valid, rej_valid}, 0);

        // fill all slots with requests, two more get refused
        for (int i = 0; i < 10; i++) push_desc(i, 1, 12'h100 + i, 12'h0A5);
        drain(1, 0);
        chk(live_count == 8, "R3 full count", 32'(live_count), 8);
        chk(rej_seen == 2, "R3 refused headers", rej_seen, 2);
        chk(q_hdr_seen == 8, "R2 admitted headers", q_hdr_seen, 8);

        // data-send and refusal traffic admitted while full
        push_desc(11, 2, 12'h321, 12'h0A5);
        push_desc(12, 3, 12'h322, 12'h0A5);
        drain(1, 0);
        chk(q_hdr_seen == 10, "R5 slotless admitted", q_hdr_seen, 10);
        chk(live_count == 8, "R5 count unchanged", 32'(live_count), 8);

        // refusals under random backpressure
        push_desc(13, 4, 12'h0F1, 12'hABC);
        push_desc(14, 0, 12'h0F2, 12'hABD);
        drain(0, 0);
        chk(rej_seen == 4, "R3 R8 refused under stall", rej_seen, 4);

        // completion on the same edge as a full-count header
        push_desc(15, 5, 12'h777, 12'h888);
        drain(1, 1);
        chk(rej_seen == 5, "R7 still refused", rej_seen, 5);
        chk(live_count == 7, "R7 count after pulse", 32'(live_count), 7);

        // drain all slots, then extra pulses at zero
        repeat (20) cycle(1, 100, 100, 0);
        chk(live_count == 0, "R6 underflow guard", 32'(live_count), 0);

        push_desc(2, 6, 12'h010, 12'h020);
        drain(1, 0);
        chk(live_count == 1, "R2 stream takes slot", 32'(live_count), 1);

        // random mix
        for (int c = 0; c < 4000; c++) begin
            if (pend.size() < 8) push_desc($urandom % 16, $urandom % 8, $urandom % 4096, $urandom % 4096);
            cycle(0, 70, 8, 0);
        end
        drain(1, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule